// File: doc/BRIEF.md
# Page-Mode ROM Read Controller

This block connects a simple synchronous read port to an asynchronous mask ROM that supports page-mode reads. The ROM can be strapped for a 32-bit or a 16-bit data path. The host presents a word address together with a one-cycle read strobe. The controller then drives the ROM address pins, the chip and output enables and the width strap. It holds the address for a computed number of clocks, captures the ROM data and returns it with a one-cycle valid pulse.

The controller remembers which page of the ROM is open. When a read falls inside that page, it waits only the short in-page access time. Otherwise it waits the full random-access time. In 16-bit mode the ROM's top data line is used as the lowest address input, so the controller drives that pin itself and zero-extends the returned half word.

If no request arrives for a set number of idle clocks, the controller deselects the chip to put it in standby. It then holds off new requests while the ROM outputs float. The wait lengths are derived from time figures in picoseconds and the clock period, rounded up to whole clocks. With the default parameters the waits are 25 clocks for a random access, 8 for an in-page access and 5 for turnaround, and the idle limit is 64 clocks.

Top module: `prom_rdctl`

## Requirements
- R1: While reset is high and on the first cycle after it, `rom_ce_n` and `rom_oe_n` are 1 and `busy` and `rd_valid` are 0.
- R2: The first read after reset has a latency of RAND_CYC clocks. Latency is counted from the clock edge that samples `rd_req` to the edge after which `rd_valid` is high.
- R3: A read whose page tag equals that of the previous read has a latency of PAGE_CYC clocks, provided the width mode is unchanged and the chip was not deselected in between.
- R4: A read to a different page in the same mode has a latency of RAND_CYC clocks.
- R5: Address mapping. In 16-bit mode (`wide_mode`=0), `rom_addr` = addr[19:1], `rom_alsb` = addr[0] and the page tag is addr[19:4]. In 32-bit mode, `rom_addr` = addr[18:0], `rom_alsb` = 0, the page tag is addr[18:3] and addr[19] is ignored.
- R6: In 32-bit mode `rd_data` holds all 32 ROM data bits. In 16-bit mode `rd_data` = {16'h0, ROM data bits 15:0}, and ROM bits 31:16 are ignored.
- R7: `rd_valid` is high for exactly one cycle per accepted read. `busy` is high from the cycle after acceptance until the `rd_valid` cycle. A `rd_req` that arrives while `busy` is high is ignored and does not change the returned data.
- R8: After IDLE_CYC idle clocks with the chip selected, `rom_ce_n` and `rom_oe_n` go to 1. `busy` then stays high for HZ_CYC clocks, and the next read takes RAND_CYC clocks.
- R9: A change of `wide_mode` closes the open page, so the next read takes RAND_CYC clocks.
- R10: While a read is waiting, `rom_ce_n` and `rom_oe_n` are 0 and `rom_addr` and `rom_alsb` hold steady until the data is captured.
- R11: `rom_wide` follows `wide_mode`, and `rom_alsb_oe` is 1 exactly when `wide_mode` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 selects the 32-bit ROM data path, 0 the 16-bit path |
| rd_req | input | 1 | Read strobe, accepted when `busy` is 0 |
| addr | input | 20 | Host word address |
| busy | output | 1 | A read or the output turnaround is in progress |
| rd_valid | output | 1 | One-cycle pulse marking `rd_data` valid |
| rd_data | output | 32 | Captured read data |
| rom_addr | output | 19 | ROM address pins |
| rom_alsb | output | 1 | Lowest address bit for the shared pin in 16-bit mode |
| rom_alsb_oe | output | 1 | Drive enable for the shared pin |
| rom_wide | output | 1 | Width strap to the ROM |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_dq | input | 32 | ROM data lines |

## Verification
Some properties are checked on every cycle by the assertions. They check that `rd_valid` never lasts two cycles and that the ROM address holds and both enables stay low for the whole of a wait. They also check that the wait counter is never reloaded while it is running, that deselecting the chip or changing the mode leaves the page tracker empty, and that a page hit is only taken while the chip is selected. Other behaviour can only be shown by the bench's scenarios. These are the exact latency of each read class (cold, page hit, page miss, after standby, after a mode flip), and the correctness of data returned from a ROM model that gives garbage when the access time is cut short. They also include the zero-extension in 16-bit mode and the handling of a request that arrives mid-access.

// File: rtl/prom_pkg.sv
package prom_pkg;

    parameter int HA_W    = 20;              // host word address width
    parameter int RA_W    = HA_W - 1;        // ROM address pins
    parameter int PG_BITS = 3;               // in-page bits on the ROM pins
    parameter int TAG_W   = RA_W - PG_BITS;  // page tag width
    parameter int DW      = 32;
    parameter int HW      = DW / 2;

    typedef enum logic [1:0] {
        S_SLEEP = 2'd0,
        S_OPEN  = 2'd1,
        S_ACC   = 2'd2,
        S_HZ    = 2'd3
    } st_e;

    typedef struct packed {
        logic [TAG_W-1:0] tag;
        logic [RA_W-1:0]  pin_a;
        logic             lsb;
    } rom_loc_t;

    // ps figure to whole clocks, rounded up, never below one
    function automatic int cyc_of(input int t_ps, input int clk_ps);
        int c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c < 1) ? 1 : c;
    endfunction

    function automatic rom_loc_t map_addr(input logic [HA_W-1:0] a, input logic wide);
        rom_loc_t r;
        if (wide) begin
            r.pin_a = a[RA_W-1:0];
            r.lsb   = 1'b0;
        end else begin
            r.pin_a = a[HA_W-1:1];
            r.lsb   = a[0];
        end
        r.tag = r.pin_a[RA_W-1:PG_BITS];
        return r;
    endfunction

endpackage

// File: rtl/prom_waitcnt.sv
module prom_waitcnt #(
    parameter int MAXC = 25,
    localparam int CW = $clog2(MAXC + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] len,
    output logic          done
);
    logic [CW-1:0] cnt;
    logic          run;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            run <= 1'b0;
        end else if (load) begin
            cnt <= len - CW'(1);
            run <= 1'b1;
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - CW'(1);
        end
    end

    assign done = run && (cnt == '0);

    // R7
    reload_idle_chk: assert property (@(posedge clk) disable iff (rst)
        load |-> !run);

    // R10
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt < CW'(MAXC)));

endmodule

// File: rtl/prom_pagetrk.sv
module prom_pagetrk #(
    parameter int TAG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wide,
    input  logic [TAG_W-1:0] tag,
    input  logic             commit,
    input  logic             drop,
    output logic             hit
);
    logic             vld;
    logic             wide_q;
    logic [TAG_W-1:0] tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld    <= 1'b0;
            wide_q <= 1'b0;
            tag_q  <= '0;
        end else begin
            wide_q <= wide;
            if (commit) begin
                vld   <= 1'b1;
                tag_q <= tag;
            end else if (drop || (wide != wide_q)) begin
                vld <= 1'b0;
            end
        end
    end

    assign hit = vld && (wide == wide_q) && (tag == tag_q);

    // R8
    drop_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (drop && !commit) |=> !vld);

    // R9
    mode_clears_chk: assert property (@(posedge clk) disable iff (rst)
        ((wide != wide_q) && !commit) |=> !vld);

endmodule

// File: rtl/prom_rdctl.sv
module prom_rdctl import prom_pkg::*; #(
    parameter int CLK_PS   = 4000,
    parameter int ACC_PS   = 100000,
    parameter int PAGE_PS  = 30000,
    parameter int HZ_PS    = 20000,
    parameter int IDLE_CYC = 64
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wide_mode,
    input  logic            rd_req,
    input  logic [HA_W-1:0] addr,
    output logic            busy,
    output logic            rd_valid,
    output logic [DW-1:0]   rd_data,
    output logic [RA_W-1:0] rom_addr,
    output logic            rom_alsb,
    output logic            rom_alsb_oe,
    output logic            rom_wide,
    output logic            rom_ce_n,
    output logic            rom_oe_n,
    input  logic [DW-1:0]   rom_dq
);
    localparam int RAND_CYC = cyc_of(ACC_PS, CLK_PS);
    localparam int PAGE_CYC = cyc_of(PAGE_PS, CLK_PS);
    localparam int HZ_CYC   = cyc_of(HZ_PS, CLK_PS);
    localparam int MAX_A    = (RAND_CYC > PAGE_CYC) ? RAND_CYC : PAGE_CYC;
    localparam int MAX_CYC  = (MAX_A > HZ_CYC) ? MAX_A : HZ_CYC;
    localparam int CW       = $clog2(MAX_CYC + 1);
    localparam int IW       = $clog2(IDLE_CYC + 1);

    st_e           st;
    logic [IW-1:0] idle_cnt;
    logic          wide_acc;
    rom_loc_t      loc;
    logic          hit, accept, timeout, load, done;
    logic [CW-1:0] len;

    always_comb loc = map_addr(addr, wide_mode);

    assign accept  = rd_req && ((st == S_SLEEP) || (st == S_OPEN));
    assign timeout = (st == S_OPEN) && !rd_req && (idle_cnt == IW'(IDLE_CYC - 1));
    assign load    = accept || timeout;
    assign len     = timeout ? CW'(HZ_CYC) : (hit ? CW'(PAGE_CYC) : CW'(RAND_CYC));
    assign busy    = (st == S_ACC) || (st == S_HZ);

    assign rom_wide    = wide_mode;
    assign rom_alsb_oe = ~wide_mode;

    prom_pagetrk #(.TAG_W(TAG_W)) u_trk (
        .clk    (clk),
        .rst    (rst),
        .wide   (wide_mode),
        .tag    (loc.tag),
        .commit (accept),
        .drop   (timeout),
        .hit    (hit)
    );

    prom_waitcnt #(.MAXC(MAX_CYC)) u_wait (
        .clk  (clk),
        .rst  (rst),
        .load (load),
        .len  (len),
        .done (done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_SLEEP;
            idle_cnt <= '0;
            wide_acc <= 1'b0;
            rom_addr <= '0;
            rom_alsb <= 1'b0;
            rom_ce_n <= 1'b1;
            rom_oe_n <= 1'b1;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            unique case (st)
                S_SLEEP, S_OPEN: begin
                    if (accept) begin
                        rom_addr <= loc.pin_a;
                        rom_alsb <= loc.lsb;
                        wide_acc <= wide_mode;
                        rom_ce_n <= 1'b0;
                        rom_oe_n <= 1'b0;
                        idle_cnt <= '0;
                        st       <= S_ACC;
                    end else if (timeout) begin
                        rom_ce_n <= 1'b1;
                        rom_oe_n <= 1'b1;
                        idle_cnt <= '0;
                        st       <= S_HZ;
                    end else if (st == S_OPEN) begin
                        idle_cnt <= idle_cnt + IW'(1);
                    end
                end
                S_ACC: begin
                    if (done) begin
                        rd_data  <= wide_acc ? rom_dq : {{HW{1'b0}}, rom_dq[HW-1:0]};
                        rd_valid <= 1'b1;
                        st       <= S_OPEN;
                    end
                end
                S_HZ: begin
                    if (done) st <= S_SLEEP;
                end
                default: st <= S_SLEEP;
            endcase
        end
    end

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(rom_addr) && $stable(rom_alsb)));

    // R10
    enables_on_chk: assert property (@(posedge clk) disable iff (rst)
        (st == S_ACC) |-> (!rom_ce_n && !rom_oe_n));

    // R8
    float_wait_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rom_ce_n) |-> busy);

    // R3
    hit_selected_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |-> !rom_ce_n);

endmodule

// File: tb/prom_rdctl_test.sv
module prom_rdctl_test;
    // 250 MHz: 4 time-unit period
    localparam int T_RAND = (100000 + 3999) / 4000;
    localparam int T_PAGE = (30000 + 3999) / 4000;
    localparam int T_HZ   = (20000 + 3999) / 4000;
    localparam int T_IDLE = 64;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wide = 1'b0;
    logic        rd_req = 1'b0;
    logic [19:0] addr = '0;
    logic        busy, rd_valid, rom_alsb, rom_alsb_oe, rom_wide, rom_ce_n, rom_oe_n;
    logic [31:0] rd_data, rom_dq;
    logic [18:0] rom_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    prom_rdctl uut (
        .clk(clk), .rst(rst), .wide_mode(wide), .rd_req(rd_req), .addr(addr),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
        .rom_addr(rom_addr), .rom_alsb(rom_alsb), .rom_alsb_oe(rom_alsb_oe),
        .rom_wide(rom_wide), .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_dq(rom_dq)
    );

    function automatic logic [31:0] mix(input logic [19:0] x);
        logic [31:0] h;
        h = {12'h0, x} * 32'h9E37_79B1;
        return h ^ (h >> 15) ^ 32'h5A17_0000;
    endfunction
    function automatic logic [15:0] f16(input logic [19:0] w);
        logic [31:0] m;
        m = mix(w);
        return m[15:0] ^ 16'h3C00;
    endfunction
    function automatic logic [31:0] f32(input logic [18:0] d);
        return mix({1'b1, d});
    endfunction

    // ROM model: data is only good once the address has been stable long enough
    logic [19:0] m_full = '0;
    logic [15:0] m_tag = '0;
    logic        m_ok = 1'b0, m_wide = 1'b0;
    int          m_age = 0, m_need = T_RAND;
    wire  [19:0] cur_full = {rom_addr, rom_alsb & ~rom_wide};

    always @(posedge clk) begin
        if (rst || rom_ce_n) begin
            m_ok   <= 1'b0;
            m_age  <= 0;
            m_need <= T_RAND;
        end else if (!m_ok || cur_full != m_full || rom_wide != m_wide) begin
            m_need <= (m_ok && rom_addr[18:3] == m_tag && rom_wide == m_wide) ? T_PAGE : T_RAND;
            m_age  <= 1;
            m_full <= cur_full;
            m_tag  <= rom_addr[18:3];
            m_wide <= rom_wide;
            m_ok   <= 1'b1;
        end else if (m_age < 1000) begin
            m_age <= m_age + 1;
        end
    end

    wire m_good = !rom_ce_n && !rom_oe_n && m_ok && (m_age + 1 >= m_need);
    assign rom_dq = !m_good  ? 32'hBAD0_BAD0 :
                    rom_wide ? f32(rom_addr) : {16'hA5C3, f16({rom_addr, rom_alsb})};

    // bench-side page expectation
    bit          exp_ok = 0;
    logic [15:0] exp_tag = '0;
    logic        exp_wide = 1'b0;
    string       cold = "R2";

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read(input logic [19:0] a, input bit poke);
        logic [15:0] t;
        bit          hit;
        int          need, lat;
        string       rq;
        logic [31:0] ed;
        t    = wide ? a[18:3] : a[19:4];
        hit  = exp_ok && (exp_wide == wide) && (t == exp_tag);
        need = hit ? T_PAGE : T_RAND;
        if (hit) rq = "R3";
        else if (exp_ok && exp_wide == wide) rq = "R4";
        else rq = cold;
        ed = wide ? f32(a[18:0]) : {16'h0, f16(a)};
        while (busy) @(negedge clk);
        rd_req = 1'b1;
        addr   = a;
        @(negedge clk);
        rd_req = 1'b0;
        addr   = 20'($urandom);
        check(busy == 1'b1, "R7", 32'(busy), 32'd1);
        check(rom_addr == (wide ? a[18:0] : a[19:1]) && rom_alsb == (wide ? 1'b0 : a[0]),
              "R5", {12'h0, rom_addr, rom_alsb}, {12'h0, (wide ? a[18:0] : a[19:1]), (wide ? 1'b0 : a[0])});
        check(!rom_ce_n && !rom_oe_n, "R10", {30'h0, rom_ce_n, rom_oe_n}, 32'h0);
        check(rom_wide == wide && rom_alsb_oe == !wide, "R11",
              {30'h0, rom_wide, rom_alsb_oe}, {30'h0, wide, !wide});
        lat = 0;
        while (!rd_valid && lat < 400) begin
            if (poke && lat == 2) begin
                rd_req = 1'b1;
                addr   = a ^ 20'h0F0F0;
            end else begin
                rd_req = 1'b0;
            end
            @(negedge clk);
            lat++;
        end
        rd_req = 1'b0;
        check(lat == need, rq, 32'(lat), 32'(need));
        check(rd_data == ed, poke ? "R7" : "R6", rd_data, ed);
        @(negedge clk);
        check(!rd_valid && !busy, "R7", {30'h0, rd_valid, busy}, 32'h0);
        exp_ok   = 1;
        exp_tag  = t;
        exp_wide = wide;
    endtask

    task automatic gap_short(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic gap_long();
        repeat (T_IDLE + T_HZ + 4) @(negedge clk);
        check(rom_ce_n && rom_oe_n && !busy, "R8",
              {29'h0, rom_ce_n, rom_oe_n, busy}, 32'h6);
        exp_ok = 0;
        cold   = "R8";
    endtask

    task automatic set_mode(input logic m);
        if (m != wide) begin
            wide   = m;
            exp_ok = 0;
            cold   = "R9";
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        logic [19:0] last;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (4) @(negedge clk);
        check(rom_ce_n && rom_oe_n && !busy && !rd_valid, "R1",
              {28'h0, rom_ce_n, rom_oe_n, busy, rd_valid}, 32'hC);
        rst = 1'b0;
        @(negedge clk);
        check(rom_ce_n && rom_oe_n && !busy && !rd_valid, "R1",
              {28'h0, rom_ce_n, rom_oe_n, busy, rd_valid}, 32'hC);

        // 16-bit mode directed
        do_read(20'h12340, 0);              // R2 cold
        do_read(20'h12341, 0);              // R3 lsb only
        do_read(20'h1234F, 0);              // R3 page end
        do_read(20'h12350, 0);              // R4 next page
        do_read(20'h12358, 1);              // R7 request during access ignored
        gap_long();
        do_read(20'h12359, 0);              // R8 cold after standby
        // 32-bit mode directed
        set_mode(1'b1);
        do_read(20'h12358, 0);              // R9 mode flip
        do_read(20'h9235F, 0);              // R5 addr[19] ignored, hit
        do_read(20'h12360, 0);              // R4
        set_mode(1'b0);
        do_read(20'h12360, 0);              // R9
        gap_short(T_IDLE / 2);
        do_read(20'h1236A, 0);              // R3 after short idle

        last = 20'h1236A;
        for (int i = 0; i < 250; i++) begin
            logic [19:0] a;
            if ($urandom_range(0, 11) == 0) set_mode(~wide);
            if ($urandom_range(0, 9) == 0) gap_long();
            else gap_short(int'($urandom_range(0, T_IDLE / 2 - 4)));
            if ($urandom_range(0, 9) < 6)
                a = wide ? {last[19:3], 3'($urandom)} : {last[19:4], 4'($urandom)};
            else
                a = 20'($urandom);
            do_read(a, $urandom_range(0, 7) == 0);
            last = a;
        end
        finish_up();
    end
endmodule